// File: doc/BRIEF.md
# Avionics Serial Word Receiver

This block takes one already-sliced serial avionics channel and turns it into checked 32-bit words. Every bit period the line delivers one sample, marked by a one-cycle `bit_en` strobe: either a data bit (`line_active` high, value on `line_bit`) or an idle period (`line_active` low). The nominal line rate is 100 kbit/s. The system clock is much faster, so `bit_en` is high on only a small fraction of cycles.

The receiver waits for an idle gap of at least `GAP_BITS` bit periods. It then collects 32 bits, least-significant first, and checks the word for odd parity. A good word is split into an 8-bit identifier and a 23-bit data field, and a single-cycle strobe announces it. A word with bad parity, or a word cut short by an idle period, is dropped, and a one-cycle error pulse reports it. One copy of the block is instantiated per channel, and the copies run independently.

Top module: `avsw_rx`

## Requirements
- R1: After a synchronous active-high reset, all strobes are low and `word_id`/`word_data` are zero. Bits received before the first idle gap of `GAP_BITS` (default 4) periods are ignored, with no strobe and no error.
- R2: A word is started only by an active bit that directly follows at least `GAP_BITS` consecutive idle periods. A word that follows a shorter gap is ignored entirely.
- R3: Bits arrive least-significant first. Received bits 0..7 form `word_id` (bit 0 is its LSB), bits 8..30 form `word_data` (bit 8 is its LSB), and bit 31 is the parity bit.
- R4: A word whose 32 bits hold an odd number of ones is accepted. `word_valid` is high for exactly one clock, the cycle after the clock edge that samples bit 31.
- R5: A complete word with an even number of ones raises no `word_valid`. Instead, `parity_error` pulses for one clock in the same position.
- R6: An idle period that arrives after 1 to 31 bits of a word drops the word and pulses `framing_error` one clock after that idle sample. At most one of the three strobes is high in any cycle. The idle period that aborts a word counts toward the next gap.
- R7: `word_id` and `word_data` change only with `word_valid`. Parity and framing errors leave them unchanged.
- R8: After bit 31 of a word, a fresh gap is needed. Active bits that follow bit 31 without a gap are ignored.
- R9: Line values in cycles where `bit_en` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a bit-period sample |
| line_active | input | 1 | 1: sample carries a data bit, 0: idle period |
| line_bit | input | 1 | Data bit value when `line_active` is high |
| word_valid | output | 1 | One-cycle strobe for an accepted word |
| word_id | output | 8 | Identifier of the last accepted word |
| word_data | output | 23 | Data field of the last accepted word |
| parity_error | output | 1 | One-cycle pulse for a word with even parity |
| framing_error | output | 1 | One-cycle pulse for a word cut short by an idle period |

## Verification
The bench goes after the edges of the sync rule:
- A three-period gap must start nothing; a receiver that counts off by one would accept that word.
- A word that runs straight into more bits must not restart; a receiver that re-arms without a gap would emit a second word.
- After an aborted word, the aborting idle plus three more must be enough; a receiver that discards the aborting idle would lose the next word.

It also targets the field and parity boundaries:
- An all-zero payload with the parity bit set is checked, along with an all-ones payload.
- A word aborted after 31 bits is checked; an off-by-one bit counter would accept or misplace it.
- After a parity error, the held identifier and data are checked; a receiver that loads the fields before the parity check would overwrite them.

Noise injected while `bit_en` is low would corrupt a word if the receiver sampled outside the strobe.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

    localparam int ID_W   = 8;
    localparam int DATA_W = 23;
    localparam int WORD_W = ID_W + DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_SHIFT = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_WORD   = 2'd1,
        EV_PARITY = 2'd2,
        EV_FRAME  = 2'd3
    } rx_event_e;

    // Bit 31 is parity, bits 30:8 data, bits 7:0 identifier.
    typedef struct packed {
        logic              par;
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   id;
    } avsw_word_t;

    function automatic logic odd_parity_ok(input avsw_word_t w);
        return ^w;
    endfunction

endpackage

// File: rtl/avsw_gap_det.sv
module avsw_gap_det #(
    parameter int GAP_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic line_active,
    output logic gap_seen
);
    localparam int GW = $clog2(GAP_BITS + 1);

    logic [GW-1:0] idle_cnt;

    // Saturating count of consecutive idle bit periods.
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (bit_en) begin
            if (line_active) begin
                idle_cnt <= '0;
            end else if (idle_cnt != GW'(GAP_BITS)) begin
                idle_cnt <= idle_cnt + GW'(1);
            end
        end
    end

    assign gap_seen = (idle_cnt == GW'(GAP_BITS));

    AST_GAP_CLEARED_BY_BIT: assert property (@(posedge clk) disable iff (rst)
        (bit_en && line_active) |=> !gap_seen); // R2

endmodule

// File: rtl/avsw_shift.sv
module avsw_shift #(
    parameter int WIDTH = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          shift,
    input  logic                          clear,
    input  logic                          bit_in,
    output logic [$clog2(WIDTH+1)-1:0]    bit_cnt,
    output logic [WIDTH-1:0]              word_next
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [WIDTH-2:0] sreg;

    // New bits enter at the top and move down, so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (start) begin
            sreg    <= {bit_in, {(WIDTH-2){1'b0}}};
            bit_cnt <= CW'(1);
        end else if (shift) begin
            sreg    <= {bit_in, sreg[WIDTH-2:1]};
            bit_cnt <= bit_cnt + CW'(1);
        end
    end

    assign word_next = {bit_in, sreg};

    AST_COUNT_BELOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < CW'(WIDTH)); // R8

endmodule

// File: rtl/avsw_check.sv
module avsw_check
    import avsw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  done,
    input  logic                  abort,
    input  avsw_word_t            word_in,
    output logic                  word_valid,
    output logic                  parity_error,
    output logic                  framing_error,
    output logic [ID_W-1:0]       word_id,
    output logic [DATA_W-1:0]     word_data
);
    rx_event_e ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q      <= EV_NONE;
            word_id   <= '0;
            word_data <= '0;
        end else begin
            ev_q <= EV_NONE;
            if (abort) begin
                ev_q <= EV_FRAME;
            end else if (done) begin
                if (odd_parity_ok(word_in)) begin
                    ev_q      <= EV_WORD;
                    word_id   <= word_in.id;
                    word_data <= word_in.data;
                end else begin
                    ev_q <= EV_PARITY;
                end
            end
        end
    end

    assign word_valid    = (ev_q == EV_WORD);
    assign parity_error  = (ev_q == EV_PARITY);
    assign framing_error = (ev_q == EV_FRAME);

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> ($stable(word_id) && $stable(word_data))); // R7
    AST_GOOD_WORD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (done && !abort && odd_parity_ok(word_in)) |=> word_valid); // R4
    AST_BAD_WORD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && !abort && !odd_parity_ok(word_in)) |=> (parity_error && !word_valid)); // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R4

endmodule

// File: rtl/avsw_rx.sv
module avsw_rx
    import avsw_pkg::*;
#(
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              line_active,
    input  logic              line_bit,
    output logic              word_valid,
    output logic [ID_W-1:0]   word_id,
    output logic [DATA_W-1:0] word_data,
    output logic              parity_error,
    output logic              framing_error
);
    rx_state_e         state_q;
    logic              gap_seen;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] word_next;
    avsw_word_t        word_s;

    logic take_bit, idle_bit, in_shift;
    logic start, last, shift, abort, clear;

    assign take_bit = bit_en && line_active;
    assign idle_bit = bit_en && !line_active;
    assign in_shift = (state_q == ST_SHIFT);
    assign start    = !in_shift && take_bit && gap_seen;
    assign last     = in_shift && take_bit && (bit_cnt == CNT_W'(WORD_W - 1));
    assign shift    = in_shift && take_bit && !last;
    assign abort    = in_shift && idle_bit;
    assign clear    = last || abort;
    assign word_s   = word_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
        end else if (start) begin
            state_q <= ST_SHIFT;
        end else if (clear) begin
            state_q <= ST_HUNT;
        end
    end

    avsw_gap_det #(.GAP_BITS(GAP_BITS)) u_gap (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .line_active (line_active),
        .gap_seen    (gap_seen)
    );

    avsw_shift #(.WIDTH(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .shift     (shift),
        .clear     (clear),
        .bit_in    (line_bit),
        .bit_cnt   (bit_cnt),
        .word_next (word_next)
    );

    avsw_check u_check (
        .clk           (clk),
        .rst           (rst),
        .done          (last),
        .abort         (abort),
        .word_in       (word_s),
        .word_valid    (word_valid),
        .parity_error  (parity_error),
        .framing_error (framing_error),
        .word_id       (word_id),
        .word_data     (word_data)
    );

    AST_NO_START_WITHOUT_GAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT && take_bit && !gap_seen) |=> (state_q == ST_HUNT)); // R2
    AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && idle_bit) |=> (framing_error && state_q == ST_HUNT)); // R6
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_valid, parity_error, framing_error})); // R6
    AST_REARM_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
        (word_valid || parity_error) |-> (state_q == ST_HUNT)); // R8
    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(state_q)); // R9

endmodule

// File: tb/test_avsw_rx.sv
module test_avsw_rx;
    import avsw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic line_active = 1'b0;
    logic line_bit = 1'b0;
    logic word_valid, parity_error, framing_error;
    logic [7:0]  word_id;
    logic [22:0] word_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    avsw_rx #(.GAP_BITS(4)) i_avsw_rx (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .line_active   (line_active),
        .line_bit      (line_bit),
        .word_valid    (word_valid),
        .word_id       (word_id),
        .word_data     (word_data),
        .parity_error  (parity_error),
        .framing_error (framing_error)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_events = 0;
    bit    finished = 1'b0;
    bit    prev_ev  = 1'b0;
    int          q_kind[$];
    logic [30:0] q_pay[$];
    string       q_req[$];
    logic [7:0]  held_id   = '0;
    logic [22:0] held_data = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] make_word(input logic [7:0] id,
                                              input logic [22:0] data, input bit good);
        logic p;
        p = ~^{data, id};
        if (!good) p = ~p;
        return {p, data, id};
    endfunction

    task automatic send_bit(input bit act, input bit val, input bit noise);
        @(negedge clk);
        line_active = act;
        line_bit    = val;
        bit_en      = 1'b1;
        repeat (BIT_CLKS - 1) begin
            @(negedge clk);
            bit_en = 1'b0;
            if (noise) begin
                line_active = 1'($urandom_range(0, 1));
                line_bit    = 1'($urandom_range(0, 1));
            end
        end
    endtask

    task automatic send_idle(input int n);
        repeat (n) send_bit(1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_raw(input logic [31:0] w, input int nbits, input bit noise);
        for (int i = 0; i < nbits; i++) send_bit(1'b1, w[i], noise);
    endtask

    task automatic expect_word(input logic [7:0] id, input logic [22:0] data, input string req);
        q_kind.push_back(1);
        q_pay.push_back({data, id});
        q_req.push_back(req);
        held_id   = id;
        held_data = data;
    endtask

    task automatic expect_err(input int kind, input string req);
        q_kind.push_back(kind);
        q_pay.push_back({held_data, held_id});
        q_req.push_back(req);
    endtask

    // Monitor: pops the scoreboard whenever a strobe appears.
    always @(negedge clk) begin
        int          kind;
        int          ek;
        logic [30:0] ep;
        string       er;
        bit          ev;
        if (!rst) begin
            ev = word_valid || parity_error || framing_error;
            if (ev) begin
                n_events++;
                check(!prev_ev, "R4", "strobe width", 2, 1);
                check($countones({word_valid, parity_error, framing_error}) == 1, "R6",
                      "single strobe", {word_valid, parity_error, framing_error}, 0);
                kind = word_valid ? 1 : (parity_error ? 2 : 3);
                if (q_kind.size() == 0) begin
                    check(1'b0, "R2", "unexpected strobe kind", kind, 0);
                end else begin
                    ek = q_kind.pop_front();
                    ep = q_pay.pop_front();
                    er = q_req.pop_front();
                    check(kind == ek, er, "strobe kind", kind, ek);
                    check({word_data, word_id} == ep, er, "data/id", {word_data, word_id}, ep);
                end
            end
            prev_ev = ev;
        end
    end

    initial begin
        int mark;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!word_valid, "R1", "word_valid after reset", word_valid, 0);
        check(!parity_error, "R1", "parity_error after reset", parity_error, 0);
        check(!framing_error, "R1", "framing_error after reset", framing_error, 0);
        check(word_id == 0, "R1", "word_id after reset", word_id, 0);
        check(word_data == 0, "R1", "word_data after reset", word_data, 0);

        // R1: word with no preceding gap after reset is ignored
        mark = n_events;
        send_raw(make_word(8'h11, 23'h00222, 1'b1), 32, 1'b0);
        check(n_events == mark, "R1", "strobes before first gap", n_events - mark, 0);

        // R3/R4: accepted words with distinct patterns
        send_idle(4);
        expect_word(8'h3C, 23'h012345, "R3");
        send_raw(make_word(8'h3C, 23'h012345, 1'b1), 32, 1'b0);
        send_idle(5);
        expect_word(8'hA5, 23'h05A5A5, "R4");
        send_raw(make_word(8'hA5, 23'h05A5A5, 1'b1), 32, 1'b0);

        // R5/R7: even parity drops the word, fields hold
        send_idle(4);
        expect_err(2, "R5");
        send_raw(make_word(8'h77, 23'h000F0F, 1'b0), 32, 1'b0);
        check(word_id == 8'hA5, "R7", "word_id held after parity error", word_id, 8'hA5);

        // R2: gap of only three periods starts nothing
        send_idle(3);
        mark = n_events;
        send_raw(make_word(8'h42, 23'h001111, 1'b1), 32, 1'b0);
        check(n_events == mark, "R2", "strobes after short gap", n_events - mark, 0);

        // R6: idle after 10 bits aborts; that idle plus three more re-arms
        send_idle(4);
        send_raw(make_word(8'h99, 23'h003333, 1'b1), 10, 1'b0);
        expect_err(3, "R6");
        send_idle(1);
        send_idle(3);
        expect_word(8'h01, 23'h400000, "R6");
        send_raw(make_word(8'h01, 23'h400000, 1'b1), 32, 1'b0);

        // R8: bits straight after bit 31 are ignored
        send_idle(4);
        expect_word(8'hFF, 23'h7FFFFF, "R8");
        mark = n_events;
        send_raw(make_word(8'hFF, 23'h7FFFFF, 1'b1), 32, 1'b0);
        send_raw(make_word(8'h12, 23'h003456, 1'b1), 32, 1'b0);
        check(n_events == mark + 1, "R8", "strobes for word plus trailing bits",
              n_events - mark, 1);

        // R9: noise while bit_en is low has no effect
        send_idle(4);
        expect_word(8'h5E, 23'h2AAAAA, "R9");
        send_raw(make_word(8'h5E, 23'h2AAAAA, 1'b1), 32, 1'b1);

        // R6: abort after 31 bits
        send_idle(4);
        send_raw(make_word(8'h6D, 23'h001234, 1'b1), 31, 1'b0);
        expect_err(3, "R6");
        send_idle(4);

        // R3: all-zero payload with parity bit set
        expect_word(8'h00, 23'h000000, "R3");
        send_raw(make_word(8'h00, 23'h000000, 1'b1), 32, 1'b0);

        repeat (4) @(negedge clk);
        check(q_kind.size() == 0, "R4", "expected strobes not seen", q_kind.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule